// File: doc/BRIEF.md
# Short-Pulse Capturing Synchronizer

This block carries one asynchronous control line into a destination clock domain without losing events, even when the source pulse is much shorter than a destination clock period. A capture flop uses the incoming line as its own clock and has its data input tied high, so any rising edge on the line leaves it set. A chain of destination-clocked flops then moves that held level into the clock domain, and the last flop of the chain is the block output.

The capture flop is released from the destination side. When the output shows the event has crossed, it clears the capture flop, but only once the incoming line has dropped low again. The first chain flop gets a whole clock period to settle out of any metastable state before the next flop samples it. Edges that arrive while an event is still held fold into that same event. Downstream logic normally watches for the rising edge of the output.

Top module: `pulse_catch_sync`

## Requirements
- R1: While reset is high and in the first cycle after reset is released, the output is low. Reset clears the capture flop and every chain flop asynchronously.
- R2: A high pulse on the input shorter than one clock period still produces exactly one rising edge on the output.
- R3: When the input rises between clock edges, the output rises on the SYNC_STAGES-th rising clock edge after that input edge (the 2nd edge with the default of 2), and never earlier.
- R4: The capture flop is not cleared while the input is high. A pulse lasting several clock periods keeps the output high until the input falls, and it yields one output event.
- R5: Once the input is low and the output is high, the capture flop clears and the output returns low SYNC_STAGES clock edges later. The output falls only after the capture flop has been low for SYNC_STAGES cycles.
- R6: Two input pulses that both arrive before the output has risen for the first one merge into a single output event.
- R7: Isolated input pulses of 0.3, 1 and 3 clock periods, each starting at any phase of the clock, each produce exactly one output rising edge and no extra ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Destination clock |
| rst_i | input | 1 | Asynchronous active-high reset for all flops |
| async_pulse_i | input | 1 | Asynchronous control input; its rising edges are the events |
| level_o | output | 1 | Event level, synchronous to clk_i |

## Verification
A new rising edge on the input and the release of the capture flop can coincide. The release happens when the input falls while the output is high, and a fresh edge at that moment must set the flop again and must not be lost to the still-active clear. The bench provokes the nearby case by firing a second short pulse a few nanoseconds after the first, before the first event has crossed. It judges the result by counting output rising edges in the scoreboard and expects exactly one, with the output low again after the quiet period.

// File: rtl/psync_pkg.sv
package psync_pkg;

  // Fewest chain flops that still give a full settle period.
  localparam int unsigned MIN_CHAIN = 2;

  // Chain depth actually built for a requested depth.
  function automatic int unsigned chain_depth(input int unsigned req);
    return (req < MIN_CHAIN) ? MIN_CHAIN : req;
  endfunction

  // Destination edges from a captured event to the output rising.
  function automatic int unsigned rise_edges(input int unsigned depth);
    return depth;
  endfunction

  // Destination edges from capture flop clearing to the output falling.
  function automatic int unsigned fall_edges(input int unsigned depth);
    return depth;
  endfunction

endpackage

// File: rtl/psync_catch.sv
module psync_catch (
  input  logic rst_i,
  input  logic pulse_i,
  input  logic release_i,
  output logic caught_o
);

  // Clear request: reset, or release from the synchronized side.
  // Release is gated inside the flop by the input level, so a fresh
  // rising edge always wins over a stale release.
  logic clear_w;
  assign clear_w = rst_i | release_i;

  always_ff @(posedge pulse_i or posedge clear_w) begin
    if (rst_i) begin
      caught_o <= 1'b0;
    end else if (release_i && !pulse_i) begin
      caught_o <= 1'b0;
    end else begin
      caught_o <= 1'b1;
    end
  end

  // R4: the held event only drops when the input is low (or on reset).
  always @(negedge caught_o) begin
    a_r4_no_clear_while_high: assert (rst_i || !pulse_i)
      else $error("R4: capture flop cleared while input high");
  end

endmodule

// File: rtl/psync_chain.sv
module psync_chain #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);

  logic [DEPTH-1:0] stage_q;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
    logic d_w;
    if (gi == 0) begin : g_head
      assign d_w = d_i;
    end else begin : g_body
      assign d_w = stage_q[gi-1];
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
        stage_q[gi] <= 1'b0;
      end else begin
        stage_q[gi] <= d_w;
      end
    end
  end

  assign q_o = stage_q[DEPTH-1];

  // R1: every chain flop is empty while reset is applied.
  a_r1_chain_reset: assert property (@(posedge clk_i)
    rst_i |-> (stage_q == '0))
    else $error("R1: chain not cleared during reset");

endmodule

// File: rtl/pulse_catch_sync.sv
module pulse_catch_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_pulse_i,
  output logic level_o
);

  import psync_pkg::*;

  localparam int unsigned DEPTH  = chain_depth(SYNC_STAGES);
  localparam int unsigned RISE_N = rise_edges(DEPTH);
  localparam int unsigned FALL_N = fall_edges(DEPTH);

  // Named internal events for the checks.
  logic caught_w;
  logic sync_w;
  logic release_w;

  psync_catch u_catch (
    .rst_i     (rst_i),
    .pulse_i   (async_pulse_i),
    .release_i (release_w),
    .caught_o  (caught_w)
  );

  psync_chain #(
    .DEPTH (DEPTH)
  ) u_chain (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (caught_w),
    .q_o   (sync_w)
  );

  // Release once the event is visible and the input has gone low.
  assign release_w = sync_w & ~async_pulse_i;
  assign level_o   = sync_w;

  // R3: an output rise must trace back to a capture RISE_N edges earlier.
  a_r3_min_latency: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sync_w) |-> $past(caught_w, RISE_N))
    else $error("R3: output rose without an earlier capture");

  // R5: output falls only after the capture flop had been cleared.
  a_r5_fall_after_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(sync_w) |-> !$past(caught_w, FALL_N))
    else $error("R5: output fell while capture flop still set");

endmodule

// File: tb/pulse_catch_sync_bench.sv
`timescale 1ns/1ps
module pulse_catch_sync_bench;

  localparam int CLK_PERIOD = 10;
  localparam int STAGES     = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b0;
  logic lvl;

  int checks = 0;
  int errors = 0;

  // Scoreboard: expected output-rise times (sampled at the falling edge).
  realtime exp_q[$];
  logic    prev_lvl = 1'b0;

  pulse_catch_sync #(
    .SYNC_STAGES (STAGES)
  ) u_pulse_catch_sync (
    .clk_i         (clk),
    .rst_i         (rst),
    .async_pulse_i (pin),
    .level_o       (lvl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: pop one expected item per observed output rise.
  always @(negedge clk) begin
    if (!rst && lvl && !prev_lvl) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected output event at %0t: actual 1 expected 0",
                 $realtime);
      end else begin
        realtime e;
        e = exp_q.pop_front();
        if ($realtime != e) begin
          errors++;
          $display("FAIL R3 rise time: actual %0t expected %0t", $realtime, e);
        end
      end
    end
    prev_lvl = lvl;
  end

  // Expected rise sampled at the falling edge after the STAGES-th rising edge.
  function automatic realtime rise_at(input realtime t0, input int phase);
    return t0 + (CLK_PERIOD - phase) + CLK_PERIOD * (STAGES - 1)
           + CLK_PERIOD / 2.0;
  endfunction

  // Driver: one isolated pulse, then quiet time and checks.
  task automatic drive_pulse(input int phase, input real width, input string req);
    realtime t0;
    @(posedge clk);
    #(phase);
    t0 = $realtime;
    exp_q.push_back(rise_at(t0, phase));
    pin = 1'b1;
    if (width > 2.0 * CLK_PERIOD) begin
      #(width - 1.0);
      // R4: output held high while the input is still high.
      check(lvl == 1'b1, "R4", "output during long pulse", int'(lvl), 1);
      #(1.0);
    end else begin
      #(width);
    end
    pin = 1'b0;
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, req, "missed events", exp_q.size(), 0);
    // R5: released and back low after the quiet period.
    check(lvl == 1'b0, "R5", "output after release", int'(lvl), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: output low during reset and right after release.
    #(CLK_PERIOD * 2 + 2);
    check(lvl == 1'b0, "R1", "output during reset", int'(lvl), 0);
    rst = 1'b0;
    @(negedge clk);
    check(lvl == 1'b0, "R1", "output after reset", int'(lvl), 0);
    repeat (2) @(negedge clk);

    // R2: sub-period pulses at fixed and random phases.
    drive_pulse(3, 0.3 * CLK_PERIOD, "R2");
    for (int i = 0; i < 6; i++) begin
      drive_pulse(int'($urandom_range(1, CLK_PERIOD - 1)), 0.3 * CLK_PERIOD, "R7");
    end

    // R7: one-period pulses at random phases.
    for (int i = 0; i < 6; i++) begin
      drive_pulse(int'($urandom_range(1, CLK_PERIOD - 1)), 1.0 * CLK_PERIOD, "R7");
    end

    // R4/R7: three-period pulses at random phases.
    for (int i = 0; i < 6; i++) begin
      drive_pulse(int'($urandom_range(1, CLK_PERIOD - 1)), 3.0 * CLK_PERIOD, "R4");
    end

    // R6: two short pulses before the first has crossed, one event expected.
    begin
      realtime t0;
      @(posedge clk);
      #(2);
      t0 = $realtime;
      exp_q.push_back(rise_at(t0, 2));
      pin = 1'b1; #(3);
      pin = 1'b0; #(3);
      pin = 1'b1; #(3);
      pin = 1'b0;
      repeat (8) @(negedge clk);
      check(exp_q.size() == 0, "R6", "merged event seen", exp_q.size(), 0);
      check(lvl == 1'b0, "R6", "output after merged event", int'(lvl), 0);
    end

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule